// File: doc/BRIEF.md
# Channel Fault Recovery Controller

This block drives the gate enables of a bank of low-side switches and protects each one against a shorted load. Every channel forms its on-command from the OR of a parallel pin and a serially written gate bit. While a global enable is high, a commanded channel turns its gate on and starts a turn-on blanking window. During this window the drain short comparator is ignored, because the drain has not settled yet. After blanking, the comparator must stay high for a filter time before the channel declares a short.

A declared short is handled in one of two ways, chosen per channel by a mode bit. In latch mode the channel stays off until software clears it or the global enable is cycled. In retry mode a fixed-length timer runs to completion with the gate held off, and command changes are ignored while it runs. The channel then resumes following its command and goes through a fresh blanking window.

All times are counted in cycles of the block clock, which serves as the timer clock. Blanking, filter and retry lengths are parameters, so a test build can use short values.

Top module: `gate_fault_guard`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, every gate_on and short_flt output is 0, whatever the other inputs are.
- R2: A channel's command is par_in OR ser_gate. With drv_enable high and no fault, gate_on goes to 1 after the first clock edge that sees the command high. Either source alone is enough.
- R3: When the command of a channel with no fault falls, gate_on goes to 0 after the next clock edge.
- R4: gate_on is 0 in the same cycle that drv_enable is 0, without waiting for a clock edge. A clock edge with drv_enable low clears any fault state, so short_flt reads 0 afterwards. A channel that is still commanded turns on again one edge after drv_enable returns high.
- R5: After turn-on, short_cmp is ignored for L = BLANK_BASE × 2^sel clock edges. sel is the channel's 2-bit field blank_sel[2i+1:2i], where 00→×1, 01→×2, 10→×4 and 11→×8.
- R6: The blanking length is taken from blank_sel at the edge where the gate turns on. Changing blank_sel while blanking runs has no effect on that window.
- R7: After blanking, a short is declared only when short_cmp is high at FILT_LEN consecutive clock edges. A run of high samples that is shorter resets the count. With the comparator high from the start, the channel is on for L + FILT_LEN edges and declares the fault on the next edge.
- R8: When retry_mode is 0, a declared short forces gate_on to 0 and sets short_flt to 1. Both hold regardless of the command until fault_clr or a drv_enable low phase.
- R9: When retry_mode is 1, a declared short holds gate_on at 0 with short_flt at 1 for RETRY_LEN edges, and command changes are ignored during this time. Then short_flt drops for one idle edge, and a still-commanded channel turns on at the next edge with a new blanking window.
- R10: If retry_mode goes to 0 while the retry timer runs, the timer is abandoned at the next edge and the channel becomes latched. It stays off with short_flt at 1.
- R11: fault_clr moves a latched channel to idle at the next edge, so short_flt drops. A still-commanded channel turns on one edge later. fault_clr has no effect on a channel that is not latched.
- R12: Each channel's gate and fault depend only on its own inputs, apart from the shared drv_enable and reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also used as the timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| drv_enable | input | 1 | Global enable, active high |
| par_in | input | NCH | Parallel on-command, one bit per channel |
| ser_gate | input | NCH | Serially written on-command, one bit per channel |
| retry_mode | input | NCH | Recovery mode per channel: 0 = latch, 1 = retry |
| blank_sel | input | 2*NCH | Blanking select, 2 bits per channel |
| short_cmp | input | NCH | Drain short comparator output per channel |
| fault_clr | input | NCH | Clears a latched fault per channel |
| gate_on | output | NCH | Gate drive level per channel |
| short_flt | output | NCH | Short fault indication per channel |

## Verification
Every result is registered once in the channel state, so each check counts edges from the edge that first sees the stimulus. A gate is due one edge after its command. A fault is due exactly L + FILT_LEN + 1 edges after turn-on. Retry ends RETRY_LEN edges after the fault, and the gate returns one edge after that. The only combinational path is the enable gating of gate_on, which is checked in the same cycle that the enable falls. The bench drives inputs and samples outputs 2 ns after each rising edge, and checks the output at every edge across the blanking sweep and the retry window, not only at the end points. This way, a result that arrives one edge early or late is caught.

// File: rtl/gfg_pkg.sv
// Package: shared types for the channel fault recovery controller.
// Assumes: nothing beyond standard SystemVerilog.
package gfg_pkg;

    // Per-channel control state
    typedef enum logic [2:0] {
        CH_IDLE  = 3'd0,   // gate off, no fault
        CH_BLANK = 3'd1,   // gate on, comparator masked
        CH_ARMED = 3'd2,   // gate on, comparator filtered
        CH_LATCH = 3'd3,   // gate off, fault held until cleared
        CH_RETRY = 3'd4    // gate off, retry timer running
    } ch_state_e;

endpackage

// File: rtl/gfg_cycle_timer.sv
// Module: down-counting cycle timer shared by blanking and retry.
// Does: loads a value, then counts down once per cycle while run is high,
//       stopping at zero; zero flags the final counted cycle.
// Assumes: load has priority over run; synchronous active-low reset.
module gfg_cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic          zero
);

    logic [TW-1:0] cnt;

    // Count register: load, decrement, or hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - TW'(1);
        end
    end

    // Terminal flag for the owner's state machine
    always_comb begin
        zero = (cnt == '0);
    end

    // A timer that is not loaded never leaves zero by itself
    AST_TMR_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero) else $error("timer left zero without load"); // R9

endmodule

// File: rtl/gfg_persist_filter.sv
// Module: consecutive-sample persistence filter for the short comparator.
// Does: raises hit on the FILT_LEN-th consecutive high sample; any low
//       sample or clear restarts the count.
// Assumes: FILT_LEN >= 1; synchronous active-low reset.
module gfg_persist_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    output logic hit
);

    localparam int FW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
    localparam logic [FW-1:0] LAST = FW'(FILT_LEN - 1);

    logic [FW-1:0] run_cnt;

    // Hit on the last sample of a full run
    always_comb begin
        hit = sample && !clear && (run_cnt == LAST);
    end

    // Run counter: restart on low sample or clear, hold once full
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_cnt <= '0;
        end else if (!sample) begin
            run_cnt <= '0;
        end else if (!hit) begin
            run_cnt <= run_cnt + FW'(1);
        end
    end

    AST_FILT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LAST) else $error("filter count beyond run length"); // R7
    AST_FILT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample) |=> (run_cnt == '0)) else $error("low sample kept count"); // R7

endmodule

// File: rtl/gfg_channel.sv
// Module: one channel of gate control with shorted-load recovery.
// Does: forms the command from parallel and serial bits, blanks the
//       comparator after turn-on, filters it, and then latches or retries.
// Assumes: blank length is BLANK_BASE << sel and fits in TW bits;
//          RETRY_LEN fits in TW bits; synchronous active-low reset.
module gfg_channel
    import gfg_pkg::*;
#(
    parameter int BLANK_BASE = 24000,
    parameter int FILT_LEN   = 12,
    parameter int RETRY_LEN  = 32000,
    parameter int TW         = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drv_enable,
    input  logic       par_in,
    input  logic       ser_gate,
    input  logic       retry_mode,
    input  logic [1:0] blank_sel,
    input  logic       short_cmp,
    input  logic       fault_clr,
    output logic       gate_on,
    output logic       short_flt
);

    localparam logic [TW-1:0] BASE_W     = TW'(BLANK_BASE);
    localparam logic [TW-1:0] RETRY_LOAD = TW'(RETRY_LEN - 1);

    ch_state_e     state, nxt;
    logic          cmd;
    logic          tmr_load, tmr_run, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic [TW-1:0] blank_load;
    logic          filt_clear, filt_hit;

    // Command and blank length for the current selection
    always_comb begin
        cmd        = par_in | ser_gate;
        blank_load = (BASE_W << blank_sel) - TW'(1);
    end

    // Next-state and timer-load decision
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!drv_enable) begin
            nxt = CH_IDLE;
        end else begin
            case (state)
                CH_IDLE: begin
                    if (cmd) begin
                        nxt      = CH_BLANK;
                        tmr_load = 1'b1;
                        tmr_val  = blank_load;
                    end
                end
                CH_BLANK: begin
                    if (!cmd)          nxt = CH_IDLE;
                    else if (tmr_zero) nxt = CH_ARMED;
                end
                CH_ARMED: begin
                    if (!cmd) begin
                        nxt = CH_IDLE;
                    end else if (filt_hit) begin
                        if (retry_mode) begin
                            nxt      = CH_RETRY;
                            tmr_load = 1'b1;
                            tmr_val  = RETRY_LOAD;
                        end else begin
                            nxt = CH_LATCH;
                        end
                    end
                end
                CH_LATCH: begin
                    if (fault_clr) nxt = CH_IDLE;
                end
                CH_RETRY: begin
                    if (!retry_mode)   nxt = CH_LATCH;
                    else if (tmr_zero) nxt = CH_IDLE;
                end
                default: nxt = CH_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    // Timer and filter control from state
    always_comb begin
        tmr_run    = (state == CH_BLANK) || (state == CH_RETRY);
        filt_clear = (state != CH_ARMED);
    end

    gfg_cycle_timer #(
        .TW (TW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .zero     (tmr_zero)
    );

    gfg_persist_filter #(
        .FILT_LEN (FILT_LEN)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (filt_clear),
        .sample (short_cmp),
        .hit    (filt_hit)
    );

    // Outputs: gate also gated directly by the enable pin
    always_comb begin
        gate_on   = drv_enable && ((state == CH_BLANK) || (state == CH_ARMED));
        short_flt = (state == CH_LATCH) || (state == CH_RETRY);
    end

    AST_ON_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CH_BLANK) || (state == CH_ARMED)) |-> $past(cmd && drv_enable))
        else $error("gate on without command"); // R2
    AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_enable) |=> (state == CH_IDLE)) else $error("enable low kept state"); // R4
    AST_BLANK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_BLANK && drv_enable) |=> (state != CH_LATCH && state != CH_RETRY))
        else $error("fault during blanking"); // R5
    AST_FAULT_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == CH_LATCH || state == CH_RETRY) |-> $past(state == CH_ARMED && short_cmp))
        else $error("fault without armed short"); // R7
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_LATCH && drv_enable && !fault_clr) |=> (state == CH_LATCH))
        else $error("latched channel released"); // R8
    AST_RETRY_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RETRY && drv_enable && retry_mode && !tmr_zero) |=> (state == CH_RETRY))
        else $error("retry cut short"); // R9
    AST_RETRY_TO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RETRY && drv_enable && !retry_mode) |=> (state == CH_LATCH))
        else $error("mode change did not latch"); // R10

endmodule

// File: rtl/gate_fault_guard.sv
// Module: top of the channel fault recovery controller.
// Does: instantiates one protected gate channel per bit of the buses.
// Assumes: clk is the timer clock; all lengths are in clk cycles;
//          synchronous active-low reset.
module gate_fault_guard #(
    parameter int NCH        = 6,
    parameter int BLANK_BASE = 24000,
    parameter int FILT_LEN   = 12,
    parameter int RETRY_LEN  = 32000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drv_enable,
    input  logic [NCH-1:0]   par_in,
    input  logic [NCH-1:0]   ser_gate,
    input  logic [NCH-1:0]   retry_mode,
    input  logic [2*NCH-1:0] blank_sel,
    input  logic [NCH-1:0]   short_cmp,
    input  logic [NCH-1:0]   fault_clr,
    output logic [NCH-1:0]   gate_on,
    output logic [NCH-1:0]   short_flt
);

    localparam int BLANK_MAX = BLANK_BASE * 8;
    localparam int TMR_MAX   = (BLANK_MAX > RETRY_LEN) ? BLANK_MAX : RETRY_LEN;
    localparam int TW        = $clog2(TMR_MAX + 1);

    // One independent channel per index
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gfg_channel #(
            .BLANK_BASE (BLANK_BASE),
            .FILT_LEN   (FILT_LEN),
            .RETRY_LEN  (RETRY_LEN),
            .TW         (TW)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .drv_enable (drv_enable),
            .par_in     (par_in[i]),
            .ser_gate   (ser_gate[i]),
            .retry_mode (retry_mode[i]),
            .blank_sel  (blank_sel[2*i +: 2]),
            .short_cmp  (short_cmp[i]),
            .fault_clr  (fault_clr[i]),
            .gate_on    (gate_on[i]),
            .short_flt  (short_flt[i])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        (!rst_n) |=> (gate_on == '0 && short_flt == '0)) else $error("outputs active after reset"); // R1

endmodule

// File: tb/gate_fault_guard_bench.sv
`timescale 1ns/1ps
module gate_fault_guard_bench;

    localparam int NCH = 2;
    localparam int BB  = 2;
    localparam int FL  = 3;
    localparam int RL  = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic [NCH-1:0]   par, ser, mode, sc, clr;
    logic [2*NCH-1:0] bsel;
    logic [NCH-1:0]   gate, flt;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    gate_fault_guard #(
        .NCH (NCH), .BLANK_BASE (BB), .FILT_LEN (FL), .RETRY_LEN (RL)
    ) u_gate_fault_guard (
        .clk (clk), .rst_n (rst_n), .drv_enable (en), .par_in (par),
        .ser_gate (ser), .retry_mode (mode), .blank_sel (bsel),
        .short_cmp (sc), .fault_clr (clr), .gate_on (gate), .short_flt (flt)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b1;
        par = '0; ser = '0; mode = '0; sc = '0; clr = '0;
        bsel = {NCH{2'b10}};
        tick(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; en = 1'b1;
        par = '1; ser = '1; mode = '0; sc = '1; clr = '0; bsel = '0;
        #2;
        // R1: reset with everything asserted
        tick(3);
        for (int c = 0; c < NCH; c++) begin
            chk(gate[c], 1'b0, "R1 gate in reset");
            chk(flt[c], 1'b0, "R1 flt in reset");
        end

        // R2/R3: each command source alone
        do_reset();
        ser[1] = 1'b1;
        chk(gate[1], 1'b0, "R2 not before edge");
        tick();
        chk(gate[1], 1'b1, "R2 serial on");
        ser[1] = 1'b0; par[1] = 1'b1;
        tick();
        chk(gate[1], 1'b1, "R2 parallel keeps on");
        chk(gate[0], 1'b0, "R12 other channel idle");
        par[1] = 1'b0;
        tick();
        chk(gate[1], 1'b0, "R3 command drop");

        // R5/R7/R8: blanking sweep, both channels, all selections, latch mode
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 4; s++) begin
                int blen;
                blen = BB << s;
                do_reset();
                bsel[2*c +: 2] = 2'(s);
                sc[c] = 1'b1;
                par[c] = 1'b1;
                for (int t = 1; t <= blen + FL + 3; t++) begin
                    tick();
                    chk(gate[c], (t <= blen + FL), "R5 gate during blank sweep");
                    chk(flt[c], (t > blen + FL), "R7 fault timing");
                    chk(gate[1-c] | flt[1-c], 1'b0, "R12 neighbour quiet");
                end
                par[c] = 1'b0; tick(2);
                par[c] = 1'b1; sc[c] = 1'b0; tick(3);
                chk(gate[c], 1'b0, "R8 latched stays off");
                chk(flt[c], 1'b1, "R8 latched flag held");
            end
        end

        // R6: selection change during blanking ignored
        do_reset();
        bsel[1:0] = 2'b00; sc[0] = 1'b1; par[0] = 1'b1;
        tick();
        bsel[1:0] = 2'b11;
        for (int t = 2; t <= BB + FL + 1; t++) begin
            tick();
            chk(flt[0], (t > BB + FL), "R6 captured blank length");
        end

        // R7: short runs below filter length never fault
        do_reset();
        bsel[1:0] = 2'b00; par[0] = 1'b1;
        tick(BB + 1);
        for (int k = 0; k < 4; k++) begin
            sc[0] = 1'b1; tick(FL - 1);
            sc[0] = 1'b0; tick();
            chk(flt[0], 1'b0, "R7 short run no fault");
            chk(gate[0], 1'b1, "R7 gate kept on");
        end
        sc[0] = 1'b1; tick(FL);
        chk(flt[0], 1'b1, "R7 full run faults");

        // R9: retry window with command toggles ignored
        do_reset();
        bsel[1:0] = 2'b00; mode[0] = 1'b1; sc[0] = 1'b1; par[0] = 1'b1;
        begin
            int tf;
            tf = BB + FL + 1;
            for (int t = 1; t <= tf + RL + 2; t++) begin
                tick();
                chk(gate[0], (t <= BB + FL) || (t >= tf + RL + 1), "R9 retry gate");
                chk(flt[0], (t >= tf) && (t <= tf + RL - 1), "R9 retry flag");
                if (t == tf + 1) par[0] = 1'b0;
                if (t == tf + 3) par[0] = 1'b1;
            end
        end

        // R10: leaving retry mode during retry latches
        do_reset();
        bsel[1:0] = 2'b00; mode[0] = 1'b1; sc[0] = 1'b1; par[0] = 1'b1;
        tick(BB + FL + 2);
        chk(flt[0], 1'b1, "R10 in retry");
        mode[0] = 1'b0;
        tick();
        chk(flt[0], 1'b1, "R10 latched after mode change");
        tick(RL + 3);
        chk(gate[0], 1'b0, "R10 stays off past retry");
        chk(flt[0], 1'b1, "R10 flag held");

        // R11: fault_clr releases latch; no effect on healthy channel
        sc[0] = 1'b0; clr[0] = 1'b1;
        tick();
        clr[0] = 1'b0;
        chk(flt[0], 1'b0, "R11 cleared");
        chk(gate[0], 1'b0, "R11 idle edge");
        tick();
        chk(gate[0], 1'b1, "R11 back on");
        clr[0] = 1'b1; tick(); clr[0] = 1'b0;
        chk(gate[0], 1'b1, "R11 clear on healthy ignored");
        chk(flt[0], 1'b0, "R11 no flag from clear");

        // R4: enable gating and fault clearing
        do_reset();
        bsel = '0; sc[0] = 1'b1; par = '1;
        tick(BB + FL + 1);
        chk(flt[0], 1'b1, "R4 setup fault");
        chk(gate[1], 1'b1, "R12 healthy neighbour on");
        en = 1'b0;
        #1;
        chk(gate[1], 1'b0, "R4 immediate gate off");
        tick();
        chk(flt[0], 1'b0, "R4 enable clears fault");
        en = 1'b1;
        tick();
        chk(gate[0], 1'b1, "R4 reenable ch0");
        chk(gate[1], 1'b1, "R4 reenable ch1");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule